// File: doc/BRIEF.md
# Fractional Multiply-Subtract with Round-Up

This block is a single-stage signed fractional datapath. It multiplies two signed factors exactly, to a product twice their width. It then shifts the product right arithmetically by a count taken from the operand width and a one-bit pre-scale `n_shift`. If any bit lost in that shift is nonzero, the shifted value is raised by one. The raised value is subtracted from a sign-extended accumulator word, and the word-wide result is returned. The second factor can be a full register word, or a halfword taken from either half of the register and sign-extended. Narrow fractions are scaled with the same hardware as full-word fractions.

A mode input picks wrapping or saturating output. Each accepted operation also produces an overflow flag and an advance-overflow flag, and both have sticky copies that collect every set value until reset. An operation is taken when `op_valid` is high on a rising clock edge. Its result and flags appear after that edge, and `res_valid` marks the cycle that follows. When `op_valid` is low, all outputs other than `res_valid` keep their values.

Top module: `qmsub_round`

## Requirements
- R1: After reset, every output is 0: `result`, `res_valid`, `ovf`, `ovf_sticky`, `adv_ovf` and `adv_sticky`.
- R2: `fac_b_sel` picks the second factor. 2'b00 and 2'b11 use all of `fac_b`. 2'b01 uses `fac_b[15:0]` sign-extended. 2'b10 uses `fac_b[31:16]` sign-extended.
- R3: The 64-bit signed product is shifted right arithmetically by (32 - `n_shift`) for a full-word factor, or by (16 - `n_shift`) for a halfword factor. The shifted value is raised by 1 when any bit shifted out is 1.
- R4: The difference is the sign-extended `acc_in` minus the raised value, computed in 64 bits. With `sat_en` = 0, `result` is the low 32 bits of that difference.
- R5: The difference is out of range when it is above 0x7FFFFFFF or below -0x80000000. With `sat_en` = 0, `ovf` equals the out-of-range condition.
- R6: An operation is special when `n_shift` = 1 and both factors, after selection, are 0x80000000. With `sat_en` = 0, a special operation gives `ovf` equal to the inverse of the out-of-range condition.
- R7: With `sat_en` = 1, `ovf` equals the out-of-range condition. An out-of-range difference clamps to 0x7FFFFFFF when it is too high and to 0x80000000 when it is too low. For a special operation the two clamp values are swapped. An in-range difference passes unchanged.
- R8: `adv_ovf` is `result[31]` XOR `result[30]` of the accepted operation.
- R9: `ovf_sticky` and `adv_sticky` are the OR of every `ovf` and `adv_ovf` value accepted since reset. With `op_valid` low, `result`, `ovf`, `adv_ovf` and both sticky flags keep their values.
- R10: `res_valid` is high in exactly the cycle after a rising edge where `op_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept the operation on this edge |
| sat_en | input | 1 | 1 = saturating output, 0 = wrapping output |
| n_shift | input | 1 | Pre-scale bit; reduces the right shift by one |
| fac_b_sel | input | 2 | Second-factor select (full, low half, high half) |
| acc_in | input | 32 | Accumulator word |
| fac_a | input | 32 | First factor |
| fac_b | input | 32 | Register holding the second factor |
| result | output | 32 | Result of the last accepted operation |
| res_valid | output | 1 | A new result was taken on the previous edge |
| ovf | output | 1 | Overflow of the last accepted operation |
| ovf_sticky | output | 1 | Accumulated overflow |
| adv_ovf | output | 1 | Advance overflow of the last accepted operation |
| adv_sticky | output | 1 | Accumulated advance overflow |

## Verification
The hardest case to reach is the special operation: both factors must be 0x80000000 with `n_shift` = 1 and a full-word select, and it then has to meet both signs of the accumulator and both output modes. Random operands almost never produce this, so the stimulus drives it directly with positive and negative accumulators in each mode. The round-up at the edge of the shift is also hard to reach. A product of -1 must be raised to exactly zero, so directed pairs such as (-1, 1) and (3, 1) are applied. The random phase then draws most operands from a small pool of extreme values, so that halfword selects and clamps are hit many times.

// File: rtl/qmsub_pkg.sv
package qmsub_pkg;

   typedef enum logic [1:0] {
      FSEL_WORD     = 2'b00,
      FSEL_LO_HALF  = 2'b01,
      FSEL_HI_HALF  = 2'b10,
      FSEL_WORD_ALT = 2'b11
   } fsel_e;

endpackage

// File: rtl/qmsub_opsel.sv
module qmsub_opsel
   import qmsub_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] reg_word,
   input  logic [1:0]        sel,
   output logic [DATA_W-1:0] fac_ext,
   output logic              is_half
);
   localparam int HALF_W = DATA_W / 2;

   fsel_e sel_e;
   assign sel_e = fsel_e'(sel);

   always_comb begin
      unique case (sel_e)
         FSEL_LO_HALF: begin
            fac_ext = {{HALF_W{reg_word[HALF_W-1]}}, reg_word[HALF_W-1:0]};
            is_half = 1'b1;
         end
         FSEL_HI_HALF: begin
            fac_ext = {{HALF_W{reg_word[DATA_W-1]}}, reg_word[DATA_W-1:HALF_W]};
            is_half = 1'b1;
         end
         default: begin
            fac_ext = reg_word;
            is_half = 1'b0;
         end
      endcase
   end

   // R2: a halfword selection is always a sign extension of its own top bit
   always_comb begin
      p_half_sext_r2: assert (!is_half ||
                              (fac_ext[DATA_W-1:HALF_W] == {HALF_W{fac_ext[HALF_W-1]}}));
   end

endmodule

// File: rtl/qmsub_prod_round.sv
module qmsub_prod_round #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]     fac_a,
   input  logic [DATA_W-1:0]     fac_b,
   input  logic                  is_half,
   input  logic                  n_shift,
   output logic [2*DATA_W-1:0]   adj,
   output logic                  special
);
   localparam int PROD_W = 2 * DATA_W;
   localparam int HALF_W = DATA_W / 2;
   localparam int SH_W   = $clog2(DATA_W + 1);
   localparam int IDX_W  = $clog2(PROD_W) + 1;

   logic signed [PROD_W-1:0] a_ext;
   logic signed [PROD_W-1:0] b_ext;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;
   logic [SH_W-1:0]          sh_amt;
   logic [IDX_W-1:0]         sh_idx;
   logic [PROD_W-1:0]        lost;
   logic                     rnd_up;
   logic [DATA_W-1:0]        most_neg;

   assign most_neg = {1'b1, {(DATA_W-1){1'b0}}};

   assign a_ext = {{DATA_W{fac_a[DATA_W-1]}}, fac_a};
   assign b_ext = {{DATA_W{fac_b[DATA_W-1]}}, fac_b};
   assign prod  = a_ext * b_ext;

   assign sh_amt = (is_half ? SH_W'(HALF_W) : SH_W'(DATA_W)) - SH_W'(n_shift);
   assign sh_idx = IDX_W'(sh_amt);

   // one sticky-detect term per product bit: set when that bit is discarded and is 1
   for (genvar i = 0; i < PROD_W; i++) begin : g_lost
      assign lost[i] = prod[i] & (IDX_W'(i) < sh_idx);
   end

   assign rnd_up  = |lost;
   assign shifted = prod >>> sh_amt;
   assign adj     = shifted + PROD_W'(rnd_up);
   assign special = n_shift && (fac_a == most_neg) && (fac_b == most_neg);

   // R3: raising by one happens only when the shift actually dropped a 1
   always_comb begin
      p_round_cause_r3: assert (!rnd_up || (prod != '0));
   end

endmodule

// File: rtl/qmsub_sub_sat.sv
module qmsub_sub_sat #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]   acc_in,
   input  logic [2*DATA_W-1:0] adj,
   input  logic                special,
   input  logic                sat_en,
   output logic [DATA_W-1:0]   res,
   output logic                ovf
);
   localparam int PROD_W = 2 * DATA_W;

   logic [PROD_W-1:0] acc_ext;
   logic [PROD_W-1:0] diff;
   logic              too_high;
   logic              too_low;
   logic              out_rng;
   logic              clamp_up;
   logic [DATA_W-1:0] max_val;
   logic [DATA_W-1:0] min_val;

   assign max_val = {1'b0, {(DATA_W-1){1'b1}}};
   assign min_val = {1'b1, {(DATA_W-1){1'b0}}};

   assign acc_ext  = {{DATA_W{acc_in[DATA_W-1]}}, acc_in};
   assign diff     = acc_ext - adj;
   assign too_high = !diff[PROD_W-1] && (|diff[PROD_W-2:DATA_W-1]);
   assign too_low  =  diff[PROD_W-1] && !(&diff[PROD_W-2:DATA_W-1]);
   assign out_rng  = too_high | too_low;
   assign clamp_up = too_high ^ special;

   always_comb begin
      if (sat_en) begin
         res = out_rng ? (clamp_up ? max_val : min_val) : diff[DATA_W-1:0];
         ovf = out_rng;
      end else begin
         res = diff[DATA_W-1:0];
         ovf = out_rng ^ special;
      end
   end

   // R7: a saturating overflow always leaves one of the two extreme values
   always_comb begin
      p_sat_clamp_r7: assert (!(sat_en && ovf) || (res == max_val) || (res == min_val));
   end

endmodule

// File: rtl/qmsub_round.sv
module qmsub_round #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              sat_en,
   input  logic              n_shift,
   input  logic [1:0]        fac_b_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] fac_a,
   input  logic [DATA_W-1:0] fac_b,
   output logic [DATA_W-1:0] result,
   output logic              res_valid,
   output logic              ovf,
   output logic              ovf_sticky,
   output logic              adv_ovf,
   output logic              adv_sticky
);
   localparam int PROD_W = 2 * DATA_W;

   if ((DATA_W < 8) || (DATA_W % 2 != 0)) begin : g_bad_width
      $error("qmsub_round: DATA_W must be even and at least 8");
   end

   logic [DATA_W-1:0] b_sel;
   logic              b_half;
   logic [PROD_W-1:0] adj;
   logic              special;
   logic [DATA_W-1:0] res_d;
   logic              ovf_d;
   logic              adv_d;

   qmsub_opsel #(.DATA_W(DATA_W)) u_opsel (
      .reg_word (fac_b),
      .sel      (fac_b_sel),
      .fac_ext  (b_sel),
      .is_half  (b_half)
   );

   qmsub_prod_round #(.DATA_W(DATA_W)) u_prod (
      .fac_a   (fac_a),
      .fac_b   (b_sel),
      .is_half (b_half),
      .n_shift (n_shift),
      .adj     (adj),
      .special (special)
   );

   qmsub_sub_sat #(.DATA_W(DATA_W)) u_sub (
      .acc_in  (acc_in),
      .adj     (adj),
      .special (special),
      .sat_en  (sat_en),
      .res     (res_d),
      .ovf     (ovf_d)
   );

   assign adv_d = res_d[DATA_W-1] ^ res_d[DATA_W-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result     <= '0;
         res_valid  <= 1'b0;
         ovf        <= 1'b0;
         ovf_sticky <= 1'b0;
         adv_ovf    <= 1'b0;
         adv_sticky <= 1'b0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            result     <= res_d;
            ovf        <= ovf_d;
            adv_ovf    <= adv_d;
            ovf_sticky <= ovf_sticky | ovf_d;
            adv_sticky <= adv_sticky | adv_d;
         end
      end
   end

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   p_valid_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(result) && $stable(ovf) && $stable(adv_ovf)));

   p_sticky_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sticky && adv_sticky) |=> (ovf_sticky && adv_sticky));

   p_sticky_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf || adv_ovf) |-> ((ovf_sticky || !ovf) && (adv_sticky || !adv_ovf)));

   p_adv_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (adv_ovf == (result[DATA_W-1] ^ result[DATA_W-2])));

endmodule

// File: tb/qmsub_round_tb.sv
module qmsub_round_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        sat_en = 1'b0;
   logic        n_shift = 1'b0;
   logic [1:0]  fac_b_sel = 2'b00;
   logic [31:0] acc_in = '0;
   logic [31:0] fac_a = '0;
   logic [31:0] fac_b = '0;
   logic [31:0] result;
   logic        res_valid, ovf, ovf_sticky, adv_ovf, adv_sticky;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   qmsub_round dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .sat_en(sat_en),
      .n_shift(n_shift), .fac_b_sel(fac_b_sel), .acc_in(acc_in),
      .fac_a(fac_a), .fac_b(fac_b), .result(result), .res_valid(res_valid),
      .ovf(ovf), .ovf_sticky(ovf_sticky), .adv_ovf(adv_ovf), .adv_sticky(adv_sticky)
   );

   // expected state
   logic [31:0] e_res = '0;
   logic        e_vld = 0, e_ovf = 0, e_ost = 0, e_adv = 0, e_ast = 0;
   string       e_req = "R1";

   task automatic ref_op(input logic [31:0] acc, input logic [31:0] a,
                         input logic [31:0] breg, input logic [1:0] sel,
                         input logic n, input logic sat,
                         output logic [31:0] r, output logic o);
      longint bv, av, p, base, q, d, lo_mask;
      bit spc, hi, lo;
      case (sel)
         2'b01:   bv = longint'($signed(breg[15:0]));
         2'b10:   bv = longint'($signed(breg[31:16]));
         default: bv = longint'($signed(breg));
      endcase
      av   = longint'($signed(a));
      p    = av * bv;
      base = (sel == 2'b01 || sel == 2'b10) ? 16 : 32;
      base = base - longint'(n);
      lo_mask = (longint'(1) <<< base) - 1;
      q = p >>> base;
      if ((p & lo_mask) != 0) q = q + 1;
      d = longint'($signed(acc)) - q;
      hi = d > longint'(32'h7FFF_FFFF);
      lo = d < -longint'(64'h8000_0000);
      spc = n && (av == -longint'(64'h8000_0000)) && (bv == -longint'(64'h8000_0000));
      if (sat) begin
         o = hi || lo;
         if (hi || lo) r = ((hi != spc) ? 32'h7FFF_FFFF : 32'h8000_0000);
         else          r = d[31:0];
      end else begin
         o = (hi || lo) != spc;
         r = d[31:0];
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_res <= '0; e_vld <= 0; e_ovf <= 0; e_ost <= 0; e_adv <= 0; e_ast <= 0;
         e_req <= "R1";
      end else begin
         logic [31:0] r;
         logic        o;
         e_vld <= op_valid;
         e_req <= cur_req;
         if (op_valid) begin
            ref_op(acc_in, fac_a, fac_b, fac_b_sel, n_shift, sat_en, r, o);
            e_res <= r;
            e_ovf <= o;
            e_adv <= r[31] ^ r[30];
            e_ost <= e_ost | o;
            e_ast <= e_ast | (r[31] ^ r[30]);
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", e_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("result", result, e_res);
         chk("res_valid(R10)", {31'b0, res_valid}, {31'b0, e_vld});
         chk("ovf", {31'b0, ovf}, {31'b0, e_ovf});
         chk("adv_ovf(R8)", {31'b0, adv_ovf}, {31'b0, e_adv});
         chk("sticky(R9)", {30'b0, ovf_sticky, adv_sticky}, {30'b0, e_ost, e_ast});
      end
   end

   task automatic op(input string req, input logic v, input logic [31:0] acc,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] sel, input logic n, input logic sat);
      @(negedge clk);
      cur_req = req;
      op_valid = v; acc_in = acc; fac_a = a; fac_b = b;
      fac_b_sel = sel; n_shift = n; sat_en = sat;
   endtask

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 9))
         0: return 32'h8000_0000;
         1: return 32'h7FFF_FFFF;
         2: return 32'h0000_0000;
         3: return 32'hFFFF_FFFF;
         4: return 32'h8000_8000;
         5: return 32'h0000_0001;
         6: return 32'h7FFF_8000;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values observed on the first cycles
      repeat (2) @(negedge clk);
      // R2: halfword selects
      op("R2", 1, 32'd100, 32'h0001_0000, 32'h0003_FFFE, 2'b01, 0, 0);
      op("R2", 1, 32'd100, 32'h0001_0000, 32'h0003_FFFE, 2'b10, 0, 0);
      op("R2", 1, 32'd100, 32'h4000_0000, 32'h0003_FFFE, 2'b11, 1, 0);
      // R3: round-up edges
      op("R3", 1, 32'd0, 32'd3, 32'd1, 2'b00, 0, 0);
      op("R3", 1, 32'd0, 32'hFFFF_FFFF, 32'd1, 2'b00, 0, 0);
      op("R3", 1, 32'd10, 32'h0000_8000, 32'h0000_0002, 2'b01, 1, 0);
      // R4, R5: wrapping and range overflow
      op("R4", 1, 32'h1234_5678, 32'h4000_0000, 32'h4000_0000, 2'b00, 1, 0);
      op("R5", 1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 0);
      // R6: special product in wrapping mode, both accumulator signs
      op("R6", 1, 32'd5, 32'h8000_0000, 32'h8000_0000, 2'b00, 1, 0);
      op("R6", 1, 32'hFFFF_FFFB, 32'h8000_0000, 32'h8000_0000, 2'b00, 1, 0);
      // R7: saturation both directions and swapped special clamp
      op("R7", 1, 32'h7FFF_FFFF, 32'h8000_0000, 32'd1, 2'b00, 1, 1);
      op("R7", 1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 1);
      op("R7", 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 2'b00, 1, 1);
      op("R7", 1, 32'd7, 32'h8000_0000, 32'h8000_0000, 2'b00, 1, 1);
      // R8: advance overflow without overflow
      op("R8", 1, 32'h4000_0000, 32'd0, 32'd0, 2'b00, 0, 0);
      // R9: idle cycles with changing inputs must not disturb outputs
      op("R9", 0, 32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 0);
      op("R9", 0, 32'h0, 32'h8000_0000, 32'h8000_0000, 2'b00, 1, 1);
      op("R10", 1, 32'd1, 32'd1, 32'd1, 2'b00, 0, 0);
      op("R10", 0, 32'd1, 32'd1, 32'd1, 2'b00, 0, 0);
      // random phase, extreme-biased
      for (int i = 0; i < 600; i++) begin
         op("R4", ($urandom_range(0, 4) != 0), pick(), pick(), pick(),
            2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      op("R9", 0, 0, 0, 0, 2'b00, 0, 0);
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule